// File: doc/BRIEF.md
# Timer Compare/Capture I/O Channel

This block is one channel of a 16-bit timer. It owns two general registers, slot A and slot B, each tied to its own pin. A free-running counter value comes in from outside. Each slot compares that counter against its general register and drives its pin when they match. Alternatively, a slot loads the counter value into its general register when an event occurs. That event is either an edge on its own pin or an event arriving from a neighbouring channel.

A CPU port writes and reads three locations. Location 0 is an 8-bit mode register: slot A's 4-bit field sits in bits 3:0 and slot B's field in bits 7:4. Locations 1 and 2 are the general registers of slot A and slot B.

Each slot has its own state machine with four states:
- `S_OFF`: output disabled.
- `S_CMP`: compare output.
- `S_CAP_PIN`: capture from the slot's own pin.
- `S_CAP_NBR`: capture from the neighbouring channel's event.

The only transition is a write of the mode register. That write moves every slot to the state its field decodes to: `to_off`, `to_cmp`, `to_cap_pin` or `to_cap_nbr`. Without a write, each slot holds its state.

In every state, a compare match (`S_CMP` only) or a capture (capture states only) produces a one-cycle pulse. The pulse comes out on `hit` for a match and on `cap` for a capture. These pulses can feed another channel's neighbour input.

Top module: `tmr_io_chan`

## Requirements
- R1: After reset the following are all 0: the mode register, both general registers, `pin_o`, `pin_oe`, `hit` and `cap`.
- R2: A write to location 0 stores all 8 bits: bits 3:0 form slot A's field and bits 7:4 form slot B's field. The stored value reads back unchanged on `bus_rdata[7:0]` with `bus_sel`=0.
- R3: A write of a field with bit 3 = 0 and bits 1:0 ≠ 00 moves the slot to `S_CMP`. At that write edge, `pin_oe` goes to 1 and `pin_o` takes the field's bit 2.
- R4: Fields 0000 and 0100 move the slot to `S_OFF`. In `S_OFF`, `pin_oe`=0 and `pin_o`=0 regardless of bit 2. A counter equal to the general register changes neither the pin nor `hit`.
- R5: In `S_CMP`, a cycle in which `cnt` equals the slot's general register sets the pin at the next edge. Bits 1:0 of the field select the action: 01 drives 0, 10 drives 1, 11 inverts the pin. The same edge raises `hit` for exactly one cycle. A mode-register write in that cycle takes precedence.
- R6: Field 10xx selects `S_CAP_PIN`. Bits 1:0 select the edge: 00 rising, 01 falling, 1x both. The pin passes through two synchroniser flops. On the third rising clock edge after the pin changes, the general register loads `cnt` and `cap` pulses for one cycle.
- R7: Field 11xx selects `S_CAP_NBR`. Slot A captures on `nbr_evt[0]` and slot B on `nbr_evt[1]`, at the clock edge that samples the event. Pin edges and the other slot's event have no effect.
- R8: In both capture states `pin_oe`=0 and `pin_o`=0.
- R9: The two slots decode their own fields independently. Every combination of the two fields gives each slot the outputs its own field alone selects.
- R10: Writes to locations 1 and 2 load slot A's and slot B's general registers. The registers read back at the same locations. A CPU write wins over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | CPU write strobe |
| bus_sel | input | 2 | Location: 0 mode, 1 slot A register, 2 slot B register |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | Read data of the selected location |
| cnt | input | 16 | Free-running counter value |
| pin_i | input | 2 | Pin input levels, [0]=A, [1]=B |
| pin_o | output | 2 | Pin output levels |
| pin_oe | output | 2 | Pin output enables |
| nbr_evt | input | 2 | Neighbour channel events for slot A / slot B |
| hit | output | 2 | Compare match pulses |
| cap | output | 2 | Capture pulses |

## Verification
The bench sweeps all 256 mode values and checks each slot's pin and enable against the slot's own field. This catches a design that lets bit 2 leak through in the disabled codes, or that swaps or cross-couples the two fields.

Each compare action is driven through two successive matches. A toggle that fails to invert twice, or a match that fires one cycle early or late, shows up as a wrong pin level or a misplaced `hit`.

Capture tests cover every edge code with both a rising and a falling pin edge. They check that `cap` is still low after two edges and high after the third. A missing synchroniser stage, or a swapped rising/falling decode, fails there.

In neighbour mode, the bench drives a pin edge and the wrong slot's event. A design that still listens to the pin, or routes the events crosswise, captures when it should not.

// File: rtl/tio_pkg.sv
package tio_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        S_OFF     = 2'd0,
        S_CMP     = 2'd1,
        S_CAP_PIN = 2'd2,
        S_CAP_NBR = 2'd3
    } slot_state_t;

    localparam logic [1:0] ACT_LOW    = 2'b01;
    localparam logic [1:0] ACT_HIGH   = 2'b10;
    localparam logic [1:0] ACT_TOGGLE = 2'b11;

    function automatic slot_state_t decode_field(input logic [FIELD_W-1:0] f);
        slot_state_t s;
        if (!f[3]) begin
            s = (f[1:0] == 2'b00) ? S_OFF : S_CMP;
        end else if (!f[2]) begin
            s = S_CAP_PIN;
        end else begin
            s = S_CAP_NBR;
        end
        return s;
    endfunction

endpackage

// File: rtl/tio_edge_sync.sv
module tio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin_i};
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/tio_slot.sv
module tio_slot
    import tio_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [FIELD_W-1:0] field,
    input  logic               gr_we,
    input  logic [CNT_W-1:0]   gr_wdata,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               pin_i,
    input  logic               nbr_evt,
    output logic [CNT_W-1:0]   gr_o,
    output logic               pin_o,
    output logic               oe_o,
    output logic               hit_o,
    output logic               cap_o
);
    slot_state_t state_q, state_d;
    logic [CNT_W-1:0] gr_q;
    logic pin_q, oe_q, hit_q, cap_q;
    logic rise, fall, pin_edge, cmp_match, cap_evt;

    tio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    // Transitions: to_off / to_cmp / to_cap_pin / to_cap_nbr on a mode write
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = decode_field(field);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (field[1:0])
            2'b00:   pin_edge = rise;
            2'b01:   pin_edge = fall;
            default: pin_edge = rise | fall;
        endcase
    end

    assign cmp_match = (state_q == S_CMP) && (cnt == gr_q) && !ctrl_we;
    assign cap_evt   = !ctrl_we &&
                       (((state_q == S_CAP_PIN) && pin_edge) ||
                        ((state_q == S_CAP_NBR) && nbr_evt));

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            oe_q  <= 1'b0;
            hit_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            hit_q <= cmp_match;
            cap_q <= cap_evt;
            if (ctrl_we) begin
                unique case (state_d)
                    S_CMP: begin
                        pin_q <= field[2];
                        oe_q  <= 1'b1;
                    end
                    S_OFF, S_CAP_PIN, S_CAP_NBR: begin
                        pin_q <= 1'b0;
                        oe_q  <= 1'b0;
                    end
                endcase
            end else if (cmp_match) begin
                unique case (field[1:0])
                    ACT_LOW:    pin_q <= 1'b0;
                    ACT_HIGH:   pin_q <= 1'b1;
                    ACT_TOGGLE: pin_q <= ~pin_q;
                    default:    pin_q <= pin_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else if (gr_we) begin
            gr_q <= gr_wdata;
        end else if (cap_evt) begin
            gr_q <= cnt;
        end
    end

    assign gr_o  = gr_q;
    assign pin_o = pin_q;
    assign oe_o  = oe_q;
    assign hit_o = hit_q;
    assign cap_o = cap_q;

    AST_WRITE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !field[3] && field[1:0] != 2'b00) |=> (oe_o && pin_o == $past(field[2]))); // R3
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |-> (!oe_o && !pin_o && !hit_o)); // R4
    AST_HIT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> oe_o); // R5
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && field[1:0] == ACT_TOGGLE && cnt == gr_q && !ctrl_we)
        |=> (pin_o != $past(pin_o))); // R5
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && field[1:0] == ACT_HIGH && cnt == gr_q && !ctrl_we) |=> pin_o); // R5
    AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o && !$past(gr_we)) |-> (gr_o == $past(cnt))); // R6
    AST_NBR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAP_NBR && nbr_evt && !ctrl_we) |=> cap_o); // R7
    AST_CAP_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAP_PIN || state_q == S_CAP_NBR) |-> (!oe_o && !pin_o)); // R8

endmodule

// File: rtl/tmr_io_chan.sv
module tmr_io_chan
    import tio_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_sel,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       pin_i,
    output logic [1:0]       pin_o,
    output logic [1:0]       pin_oe,
    input  logic [1:0]       nbr_evt,
    output logic [1:0]       hit,
    output logic [1:0]       cap
);
    localparam int N_SLOTS = 2;
    localparam int CTRL_W  = N_SLOTS * FIELD_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              ctrl_we;
    logic [CNT_W-1:0]  gr_w [N_SLOTS];

    assign ctrl_we = bus_we && (bus_sel == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [FIELD_W-1:0] field_w;
        logic               gr_we_w;

        assign field_w = ctrl_we ? bus_wdata[g*FIELD_W +: FIELD_W]
                                 : ctrl_q[g*FIELD_W +: FIELD_W];
        assign gr_we_w = bus_we && (bus_sel == 2'(g + 1));

        tio_slot #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we),
            .field   (field_w),
            .gr_we   (gr_we_w),
            .gr_wdata(bus_wdata),
            .cnt     (cnt),
            .pin_i   (pin_i[g]),
            .nbr_evt (nbr_evt[g]),
            .gr_o    (gr_w[g]),
            .pin_o   (pin_o[g]),
            .oe_o    (pin_oe[g]),
            .hit_o   (hit[g]),
            .cap_o   (cap[g])
        );
    end

    always_comb begin
        unique case (bus_sel)
            2'd0:    bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            2'd1:    bus_rdata = gr_w[0];
            2'd2:    bus_rdata = gr_w[1];
            default: bus_rdata = '0;
        endcase
    end

    AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (bus_sel != 2'd0 || bus_rdata[CTRL_W-1:0] == $past(bus_wdata[CTRL_W-1:0]))); // R2

endmodule

// File: tb/tmr_io_chan_test.sv
module tmr_io_chan_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [1:0]  bus_sel;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] cnt;
    logic [1:0]  pin_i;
    logic [1:0]  pin_o;
    logic [1:0]  pin_oe;
    logic [1:0]  nbr_evt;
    logic [1:0]  hit;
    logic [1:0]  cap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tmr_io_chan uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .nbr_evt(nbr_evt),
        .hit(hit), .cap(cap)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        rst_n = 1'b0; bus_we = 1'b0; bus_sel = 2'd0; bus_wdata = '0;
        cnt = 16'hFFFF; pin_i = 2'b00; nbr_evt = 2'b00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, r); chk(r == 16'h0, "R1 mode", r, 0);
        rd(2'd1, r); chk(r == 16'h0, "R1 grA", r, 0);
        rd(2'd2, r); chk(r == 16'h0, "R1 grB", r, 0);
        chk({pin_o, pin_oe, hit, cap} == 8'h0, "R1 outputs", {pin_o, pin_oe, hit, cap}, 0);

        // R2 R3 R4 R8 R9: all 256 mode values
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 16'(v));
            rd(2'd0, r);
            chk(r == 16'(v), "R2 readback", r, v);
            for (int s = 0; s < 2; s++) begin
                logic [3:0] f;
                bit eo, eout;
                f = 4'((v >> (4 * s)) & 15);
                eo = !f[3] && f[1:0] != 2'b00;
                eout = eo ? f[2] : 1'b0;
                chk(pin_oe[s] == eo && pin_o[s] == eout,
                    eo ? "R3/R9 init level" : (f[3] ? "R8/R9 capture no drive" : "R4/R9 disabled"),
                    {pin_oe[s], pin_o[s]}, {eo, eout});
            end
        end

        // R10 general register access
        wr(2'd1, 16'h1234); wr(2'd2, 16'hBEEF);
        rd(2'd1, r); chk(r == 16'h1234, "R10 grA", r, 16'h1234);
        rd(2'd2, r); chk(r == 16'hBEEF, "R10 grB", r, 16'hBEEF);

        // R5 compare actions, R4 disabled codes
        for (int s = 0; s < 2; s++) begin
            for (int code = 0; code < 8; code++) begin
                logic [15:0] g;
                bit lvl, on;
                g = 16'(100 + code * 7 + s);
                on = (code & 3) != 0;
                cnt = 16'h0;
                wr(2'(1 + s), g);
                wr(2'd0, 16'(code << (4 * s)));
                lvl = on ? code[2] : 1'b0;
                chk(pin_oe[s] == on && pin_o[s] == lvl, "R3 after write", {pin_oe[s], pin_o[s]}, {on, lvl});
                cnt = g - 16'd1; tick();
                chk(pin_o[s] == lvl && hit[s] == 1'b0, "R5 no early match", {pin_o[s], hit[s]}, {lvl, 1'b0});
                for (int m = 0; m < 2; m++) begin
                    cnt = g; tick();
                    if (on) lvl = ((code & 3) == 1) ? 1'b0 : ((code & 3) == 2) ? 1'b1 : ~lvl;
                    chk(pin_o[s] == lvl && hit[s] == on && pin_oe[s] == on,
                        on ? "R5 match action" : "R4 disabled match",
                        {pin_oe[s], pin_o[s], hit[s]}, {on, lvl, on});
                    cnt = g + 16'd1; tick();
                    chk(hit[s] == 1'b0 && pin_o[s] == lvl, "R5 hit one cycle", {hit[s], pin_o[s]}, {1'b0, lvl});
                end
            end
        end

        // R6 pin capture on each edge code
        for (int s = 0; s < 2; s++) begin
            for (int code = 8; code < 12; code++) begin
                logic [15:0] v1, v2, expg;
                bit er, ef;
                er = (code & 3) != 1;
                ef = (code & 3) != 0;
                wr(2'(1 + s), 16'h0);
                wr(2'd0, 16'(code << (4 * s)));
                chk(pin_oe[s] == 1'b0, "R8 capture no oe", pin_oe[s], 0);
                v1 = 16'(16'h3000 + code * 16 + s);
                cnt = v1; pin_i[s] = 1'b1;
                tick(); tick();
                chk(cap[s] == 1'b0, "R6 sync latency rise", cap[s], 0);
                tick();
                chk(cap[s] == er && cap[1-s] == 1'b0, "R6 rising capture", cap, er << s);
                expg = er ? v1 : 16'h0;
                rd(2'(1 + s), r); chk(r == expg, "R6 rise value", r, expg);
                tick();
                chk(cap[s] == 1'b0, "R6 pulse one cycle", cap[s], 0);
                v2 = v1 + 16'h0100;
                cnt = v2; pin_i[s] = 1'b0;
                tick(); tick();
                chk(cap[s] == 1'b0, "R6 sync latency fall", cap[s], 0);
                tick();
                chk(cap[s] == ef, "R6 falling capture", cap[s], ef);
                if (ef) expg = v2;
                rd(2'(1 + s), r); chk(r == expg, "R6 fall value", r, expg);
                tick();
            end
        end

        // R7 neighbour capture
        for (int s = 0; s < 2; s++) begin
            for (int code = 12; code < 16; code++) begin
                logic [15:0] v;
                bit seen;
                v = 16'(16'h7000 + code * 3 + s * 64);
                wr(2'(1 + s), 16'h0);
                wr(2'd0, 16'(code << (4 * s)));
                cnt = v;
                seen = 0;
                pin_i[s] = 1'b1;
                for (int k = 0; k < 4; k++) begin tick(); if (cap[s]) seen = 1; end
                pin_i[s] = 1'b0;
                for (int k = 0; k < 4; k++) begin tick(); if (cap[s]) seen = 1; end
                chk(!seen, "R7 pin ignored", seen, 0);
                nbr_evt[1-s] = 1'b1; tick(); nbr_evt = 2'b00;
                chk(cap[s] == 1'b0, "R7 other event ignored", cap[s], 0);
                rd(2'(1 + s), r); chk(r == 16'h0, "R7 no capture value", r, 0);
                nbr_evt[s] = 1'b1; tick(); nbr_evt = 2'b00;
                chk(cap[s] == 1'b1, "R7 neighbour capture", cap[s], 1);
                rd(2'(1 + s), r); chk(r == v, "R7 capture value", r, v);
                tick();
                chk(cap[s] == 1'b0, "R7 pulse one cycle", cap[s], 0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule